// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

In a multithreaded out-of-order core, only one hardware thread can retire an instruction through a given commit slot. This block makes that choice for the slot. Each thread supplies a status code, a flag for an empty reorder buffer, a flag for a ready buffer head and the sequence number of that head. The block combines these with an active-thread mask and a policy select, and it returns a valid flag and the number of the chosen thread. The selection is combinational. The only state is the rotating priority order that the round-robin policy uses.

There are three policies. Round-robin scans a stored priority order from the front and takes the first thread that qualifies. When the surrounding logic consumes that choice, the chosen thread moves to the back of the order. Oldest-ready picks the qualifying thread whose head instruction has the smallest sequence number. Aggressive makes the same choice as oldest-ready. It exists so that a wide retire stage can call the selector once for each slot in a cycle. A build with one thread skips all arbitration and uses a status test alone.

Top module: `cmt_thread_sel`

## Requirements
- R1: The policy select encodes 0 as aggressive, 1 as round-robin and 2 as oldest-ready. Code 3 yields no selection.
- R2: After reset, the round-robin order holds the thread numbers 0 up to N-1, with the smallest at the front.
- R3: Under round-robin, the result is the first thread in the stored order that is active, has status Idle or Running and has a ready head. The empty flag is not considered.
- R4: When the accept strobe is high in a cycle where round-robin has a valid selection, the selected thread moves to the back of the order at the next clock edge. All other threads keep their relative order. With any other policy, or with no accept, the order does not change.
- R5: Under oldest-ready and aggressive, a thread qualifies when it is active, its reorder buffer is not empty, its head is ready and its status is Idle, Running or FetchTrapPending.
- R6: Under oldest-ready and aggressive, the result is the qualifying thread with the smallest head sequence number. On a tie, the lower thread number wins.
- R7: When no thread qualifies, the valid output is low and the thread output is 0.
- R8: In a one-thread build, thread 0 is returned with valid high exactly when its status is Idle, Running or FetchTrapPending. The policy and all other inputs are ignored.
- R9: The status field is 3 bits per thread, packed with thread 0 in the lowest bits. The codes are: 0 Idle, 1 Running, 2 buffer squashing, 3 trap pending and 4 fetch trap pending. Codes 2, 3, 5, 6 and 7 never qualify, under any policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Selection policy code |
| active_i | input | NUM_THREADS | Active-thread mask |
| status_i | input | 3*NUM_THREADS | Per-thread status codes |
| rob_empty_i | input | NUM_THREADS | Reorder buffer empty, per thread |
| head_ready_i | input | NUM_THREADS | Buffer head ready to retire, per thread |
| head_seq_i | input | SEQ_W*NUM_THREADS | Head sequence number, per thread |
| accept_i | input | 1 | The current selection is consumed |
| sel_valid_o | output | 1 | A thread is selected |
| sel_tid_o | output | TID_W | Selected thread number |

## Verification
The round-robin tests use three patterns.
- With every thread eligible, accepts are issued repeatedly. This shows whether the order rotates, and also whether it holds when no accept is given.
- Ineligible threads are placed at the front of the order. This shows whether the scan skips them correctly.
- A thread is removed from the middle of the order. This separates a correct move-to-back from a plain rotation.

The oldest-ready tests use sequence patterns with a unique minimum, with a tie and with a changing minimum. These are combined with empty buffers and each status code in turn, so that a wrong age comparison can be told apart from a wrong eligibility rule. Further tests confirm that aggressive selection matches oldest-ready and leaves the round-robin order untouched. They also cover the reserved policy code, the case where no thread qualifies, and the one-thread build.

// File: rtl/cmt_sel_pkg.sv
package cmt_sel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_ROB_SQ = 3'd2,
    ST_TRAP   = 3'd3,
    ST_FTRAP  = 3'd4
  } thr_st_e;

  typedef enum logic [1:0] {
    POL_AGGR   = 2'd0,
    POL_RR     = 2'd1,
    POL_OLDEST = 2'd2,
    POL_RSVD   = 2'd3
  } pol_e;

  function automatic logic st_rr_ok(input logic [2:0] s);
    return (s == ST_IDLE) || (s == ST_RUN);
  endfunction

  function automatic logic st_age_ok(input logic [2:0] s);
    return (s == ST_IDLE) || (s == ST_RUN) || (s == ST_FTRAP);
  endfunction

endpackage

// File: rtl/cmt_elig.sv
module cmt_elig
  import cmt_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS-1:0]   active_i,
  input  logic [3*NUM_THREADS-1:0] status_i,
  input  logic [NUM_THREADS-1:0]   rob_empty_i,
  input  logic [NUM_THREADS-1:0]   head_ready_i,
  output logic [NUM_THREADS-1:0]   rr_elig_o,
  output logic [NUM_THREADS-1:0]   age_elig_o
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [2:0] st;
    assign st = status_i[3*t +: 3];
    assign rr_elig_o[t]  = active_i[t] & head_ready_i[t] & st_rr_ok(st);
    assign age_elig_o[t] = active_i[t] & head_ready_i[t] & ~rob_empty_i[t]
                         & st_age_ok(st);
  end

endmodule

// File: rtl/cmt_age_pick.sv
module cmt_age_pick #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0]       elig_i,
  input  logic [SEQ_W*NUM_THREADS-1:0] seq_i,
  output logic                         valid_o,
  output logic [TID_W-1:0]             tid_o
);

  logic [SEQ_W-1:0] best_seq;

  // strict compare keeps the lower thread on ties
  always_comb begin
    valid_o  = 1'b0;
    tid_o    = '0;
    best_seq = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (elig_i[t] && (!valid_o || seq_i[t*SEQ_W +: SEQ_W] < best_seq)) begin
        valid_o  = 1'b1;
        tid_o    = TID_W'(t);
        best_seq = seq_i[t*SEQ_W +: SEQ_W];
      end
    end
  end

endmodule

// File: rtl/cmt_rr_order.sv
module cmt_rr_order #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_THREADS-1:0]       elig_i,
  input  logic                         advance_i,
  output logic                         valid_o,
  output logic [TID_W-1:0]             tid_o,
  output logic [TID_W*NUM_THREADS-1:0] order_o
);

  logic [TID_W-1:0] order_q [NUM_THREADS];
  logic [TID_W-1:0] order_d [NUM_THREADS];
  logic [TID_W-1:0] hit_pos;

  always_comb begin
    valid_o = 1'b0;
    hit_pos = '0;
    for (int p = 0; p < NUM_THREADS; p++) begin
      if (!valid_o && elig_i[order_q[p]]) begin
        valid_o = 1'b1;
        hit_pos = TID_W'(p);
      end
    end
    tid_o = valid_o ? order_q[hit_pos] : '0;
  end

  // move the consumed entry to the tail, close the gap
  always_comb begin
    for (int p = 0; p < NUM_THREADS; p++) order_d[p] = order_q[p];
    if (advance_i && valid_o) begin
      for (int p = 0; p < NUM_THREADS - 1; p++) begin
        if (TID_W'(p) >= hit_pos) order_d[p] = order_q[p+1];
      end
      order_d[NUM_THREADS-1] = order_q[hit_pos];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_THREADS; p++) order_q[p] <= TID_W'(p);
    end else begin
      for (int p = 0; p < NUM_THREADS; p++) order_q[p] <= order_d[p];
    end
  end

  for (genvar p = 0; p < NUM_THREADS; p++) begin : g_flat
    assign order_o[p*TID_W +: TID_W] = order_q[p];
  end

endmodule

// File: rtl/cmt_thread_sel.sv
module cmt_thread_sel
  import cmt_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0]                   policy_i,
  input  logic [NUM_THREADS-1:0]       active_i,
  input  logic [3*NUM_THREADS-1:0]     status_i,
  input  logic [NUM_THREADS-1:0]       rob_empty_i,
  input  logic [NUM_THREADS-1:0]       head_ready_i,
  input  logic [SEQ_W*NUM_THREADS-1:0] head_seq_i,
  input  logic                         accept_i,
  output logic                         sel_valid_o,
  output logic [TID_W-1:0]             sel_tid_o
);

  logic [TID_W*NUM_THREADS-1:0] order_flat;

  if (NUM_THREADS == 1) begin : g_single
    assign order_flat  = '0;
    assign sel_valid_o = st_age_ok(status_i[2:0]);
    assign sel_tid_o   = '0;
  end else begin : g_multi
    logic [NUM_THREADS-1:0] rr_elig, age_elig;
    logic                   rr_v, age_v;
    logic [TID_W-1:0]       rr_t, age_t;
    logic                   rr_adv;

    assign rr_adv = accept_i && (policy_i == POL_RR);

    cmt_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
      .active_i    (active_i),
      .status_i    (status_i),
      .rob_empty_i (rob_empty_i),
      .head_ready_i(head_ready_i),
      .rr_elig_o   (rr_elig),
      .age_elig_o  (age_elig)
    );

    cmt_age_pick #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_age (
      .elig_i (age_elig),
      .seq_i  (head_seq_i),
      .valid_o(age_v),
      .tid_o  (age_t)
    );

    cmt_rr_order #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_rr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .elig_i   (rr_elig),
      .advance_i(rr_adv),
      .valid_o  (rr_v),
      .tid_o    (rr_t),
      .order_o  (order_flat)
    );

    always_comb begin
      sel_valid_o = 1'b0;
      sel_tid_o   = '0;
      unique case (policy_i)
        POL_AGGR, POL_OLDEST: begin
          sel_valid_o = age_v;
          sel_tid_o   = age_t;
        end
        POL_RR: begin
          sel_valid_o = rr_v;
          sel_tid_o   = rr_t;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cmt_thread_sel_chk.sv
module cmt_thread_sel_chk #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [1:0]                   policy_i,
  input logic [NUM_THREADS-1:0]       active_i,
  input logic [3*NUM_THREADS-1:0]     status_i,
  input logic [NUM_THREADS-1:0]       rob_empty_i,
  input logic [NUM_THREADS-1:0]       head_ready_i,
  input logic [SEQ_W*NUM_THREADS-1:0] head_seq_i,
  input logic                         accept_i,
  input logic                         sel_valid_o,
  input logic [TID_W-1:0]             sel_tid_o,
  input logic [TID_W*NUM_THREADS-1:0] order_flat
);

  localparam bit MULTI = (NUM_THREADS > 1);

  logic [2:0]             sel_st;
  logic [SEQ_W-1:0]       sel_seq;
  logic                   rr_ok, age_ok, older_exists;
  logic [NUM_THREADS-1:0] seen;
  logic                   age_pol;

  assign age_pol = (policy_i == 2'd0) || (policy_i == 2'd2);

  always_comb begin
    sel_st  = status_i[3*int'(sel_tid_o) +: 3];
    sel_seq = head_seq_i[SEQ_W*int'(sel_tid_o) +: SEQ_W];
    rr_ok   = active_i[sel_tid_o] && head_ready_i[sel_tid_o]
              && (sel_st == 3'd0 || sel_st == 3'd1);
    age_ok  = active_i[sel_tid_o] && head_ready_i[sel_tid_o] && !rob_empty_i[sel_tid_o]
              && (sel_st == 3'd0 || sel_st == 3'd1 || sel_st == 3'd4);
    older_exists = 1'b0;
    seen = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (active_i[t] && head_ready_i[t] && !rob_empty_i[t]
          && (status_i[3*t +: 3] == 3'd0 || status_i[3*t +: 3] == 3'd1
              || status_i[3*t +: 3] == 3'd4)
          && ((head_seq_i[SEQ_W*t +: SEQ_W] < sel_seq)
              || (head_seq_i[SEQ_W*t +: SEQ_W] == sel_seq && t < int'(sel_tid_o))))
        older_exists = 1'b1;
      seen[order_flat[TID_W*t +: TID_W]] = 1'b1;
    end
  end

  a_r1_rsvd_policy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MULTI && policy_i == 2'd3) |-> !sel_valid_o);

  a_r3_rr_pick_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MULTI && sel_valid_o && policy_i == 2'd1) |-> rr_ok);

  a_r5_age_pick_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MULTI && sel_valid_o && age_pol) |-> age_ok);

  a_r6_age_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MULTI && sel_valid_o && age_pol) |-> !older_exists);

  a_r4_order_perm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    MULTI |-> (seen == {NUM_THREADS{1'b1}}));

  a_r4_hold_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_i && policy_i == 2'd1 && sel_valid_o) |=> $stable(order_flat));

  a_r7_invalid_tid_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_valid_o |-> (sel_tid_o == '0));

  a_r8_single_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !MULTI |-> (sel_valid_o == (status_i[2:0] == 3'd0 || status_i[2:0] == 3'd1
                                || status_i[2:0] == 3'd4)));

endmodule

bind cmt_thread_sel cmt_thread_sel_chk #(
  .NUM_THREADS(NUM_THREADS),
  .SEQ_W      (SEQ_W)
) u_chk (.*);

// File: tb/cmt_thread_sel_bench.sv
module cmt_thread_sel_bench;

  localparam int N  = 4;
  localparam int SW = 16;

  typedef struct {
    logic       v;
    logic [1:0] t;
    string      tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    policy;
  logic [N-1:0]  active, empty, ready;
  logic [3*N-1:0] status;
  logic [SW*N-1:0] seq;
  logic          accept;
  logic          sel_v;
  logic [1:0]    sel_t;

  logic [2:0]    s_status;
  logic          s_v;
  logic [0:0]    s_t;

  int total = 0, bad = 0;
  bit done = 0;
  exp_t exp_q[$];
  int mdl[N];
  event drv_ev;

  always #4 clk = ~clk;

  cmt_thread_sel #(.NUM_THREADS(N), .SEQ_W(SW)) u_cmt_thread_sel (
    .clk_i(clk), .rst_ni(rst_ni), .policy_i(policy), .active_i(active),
    .status_i(status), .rob_empty_i(empty), .head_ready_i(ready),
    .head_seq_i(seq), .accept_i(accept), .sel_valid_o(sel_v), .sel_tid_o(sel_t));

  cmt_thread_sel #(.NUM_THREADS(1), .SEQ_W(SW)) u_single (
    .clk_i(clk), .rst_ni(rst_ni), .policy_i(2'd3), .active_i(1'b0),
    .status_i(s_status), .rob_empty_i(1'b1), .head_ready_i(1'b0),
    .head_seq_i('0), .accept_i(1'b0), .sel_valid_o(s_v), .sel_tid_o(s_t));

  function automatic logic rr_st(input logic [2:0] s);
    return s == 3'd0 || s == 3'd1;
  endfunction
  function automatic logic age_st(input logic [2:0] s);
    return s == 3'd0 || s == 3'd1 || s == 3'd4;
  endfunction

  function automatic logic [11:0] pk_st(input logic [2:0] a, b, c, d);
    return {d, c, b, a};
  endfunction
  function automatic logic [63:0] pk_seq(input logic [15:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  task automatic chk(input logic av, input logic [1:0] at, input logic ev,
                     input logic [1:0] et, input string tag);
    total++;
    if (av !== ev || (ev && at !== et) || (!ev && at !== 2'd0)) begin
      bad++;
      $display("FAIL %s: got v=%0b tid=%0d, exp v=%0b tid=%0d", tag, av, at, ev, et);
    end
  endtask

  task automatic step(input logic [1:0] pol, input logic [3:0] act,
                      input logic [11:0] st, input logic [3:0] emp,
                      input logic [3:0] rdy, input logic [63:0] sq,
                      input logic acc, input string tag);
    exp_t e;
    int hit;
    logic [15:0] best;
    @(negedge clk);
    policy = pol; active = act; status = st; empty = emp; ready = rdy;
    seq = sq; accept = acc;
    e.v = 1'b0; e.t = 2'd0; e.tag = tag; hit = -1; best = '0;
    if (pol == 2'd1) begin
      for (int p = 0; p < N; p++) begin
        int th = mdl[p];
        if (hit < 0 && act[th] && rdy[th] && rr_st(st[3*th +: 3])) hit = p;
      end
      if (hit >= 0) begin e.v = 1'b1; e.t = 2'(mdl[hit]); end
    end else if (pol != 2'd3) begin
      for (int t = 0; t < N; t++) begin
        if (act[t] && rdy[t] && !emp[t] && age_st(st[3*t +: 3])
            && (!e.v || sq[16*t +: 16] < best)) begin
          e.v = 1'b1; e.t = 2'(t); best = sq[16*t +: 16];
        end
      end
    end
    exp_q.push_back(e);
    -> drv_ev;
    if (acc && pol == 2'd1 && hit >= 0) begin
      int mv = mdl[hit];
      for (int p = hit; p < N - 1; p++) mdl[p] = mdl[p+1];
      mdl[N-1] = mv;
    end
  endtask

  // monitor
  initial begin
    forever begin
      exp_t e;
      @(drv_ev);
      #2;
      e = exp_q.pop_front();
      chk(sel_v, sel_t, e.v, e.t, e.tag);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: got hung, exp completion");
    finish_run();
  end

  initial begin
    logic [11:0] run4;
    logic [63:0] sq_a;
    for (int p = 0; p < N; p++) mdl[p] = p;
    run4 = pk_st(3'd1, 3'd1, 3'd1, 3'd1);
    sq_a = pk_seq(16'd40, 16'd12, 16'd30, 16'd12);
    policy = 2'd1; active = '0; status = '0; empty = '1; ready = '0;
    seq = '0; accept = 1'b0; s_status = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R2 reset order, R4 hold without accept
    step(2'd1, 4'hF, run4, 4'h0, 4'hF, '0, 1'b0, "R2 reset order front is 0");
    step(2'd1, 4'hF, run4, 4'h0, 4'hF, '0, 1'b0, "R4 no accept keeps order");
    step(2'd1, 4'hF, run4, 4'h0, 4'hF, '0, 1'b1, "R3 pick before accept");
    step(2'd1, 4'hF, run4, 4'h0, 4'hF, '0, 1'b1, "R4 rotated to thread 1");
    // R9 squashing thread skipped, R3 not-ready skipped
    step(2'd1, 4'hF, pk_st(3'd1, 3'd1, 3'd2, 3'd1), 4'h0, 4'hF, '0, 1'b0,
         "R9 squashing status skipped in round-robin");
    step(2'd1, 4'hF, pk_st(3'd1, 3'd1, 3'd2, 3'd1), 4'h0, 4'h7, '0, 1'b1,
         "R3 not-ready skipped, middle pick");
    step(2'd1, 4'hF, run4, 4'h0, 4'hF, '0, 1'b0, "R4 middle entry moved to tail");
    step(2'd1, 4'h2, pk_st(3'd0, 3'd0, 3'd0, 3'd0), 4'hF, 4'hF, '0, 1'b0,
         "R3 inactive ignored, idle qualifies, empty ignored");
    step(2'd1, 4'hF, pk_st(3'd4, 3'd3, 3'd2, 3'd5), 4'h0, 4'hF, '0, 1'b0,
         "R9 fetch-trap not round-robin eligible");
    // oldest-ready
    step(2'd2, 4'hF, run4, 4'h0, 4'hF, sq_a, 1'b0, "R6 tie goes to lower thread");
    step(2'd2, 4'hF, run4, 4'h2, 4'hF, sq_a, 1'b0, "R5 empty buffer excluded");
    step(2'd2, 4'hF, pk_st(3'd1, 3'd1, 3'd1, 3'd4), 4'h2, 4'hF, sq_a, 1'b0,
         "R5 fetch-trap eligible in oldest-ready");
    step(2'd2, 4'hF, pk_st(3'd1, 3'd1, 3'd1, 3'd3), 4'h2, 4'hF, sq_a, 1'b0,
         "R9 trap pending excluded");
    step(2'd2, 4'hF, pk_st(3'd1, 3'd1, 3'd5, 3'd3), 4'h2, 4'hF, sq_a, 1'b0,
         "R9 code 5 excluded");
    step(2'd2, 4'hF, run4, 4'h0, 4'hF, pk_seq(16'd9, 16'd8, 16'd7, 16'd900), 1'b0,
         "R6 smallest sequence wins");
    // aggressive
    step(2'd0, 4'hF, run4, 4'h0, 4'hF, sq_a, 1'b1, "R1 aggressive matches oldest");
    step(2'd1, 4'hF, run4, 4'h0, 4'hF, '0, 1'b0, "R4 aggressive accept leaves order");
    step(2'd3, 4'hF, run4, 4'h0, 4'hF, sq_a, 1'b1, "R1 reserved policy no selection");
    step(2'd1, 4'hF, run4, 4'h0, 4'hF, '0, 1'b0, "R4 reserved accept leaves order");
    step(2'd2, 4'hF, run4, 4'h0, 4'h0, sq_a, 1'b0, "R7 nothing ready gives none");
    step(2'd1, 4'h0, run4, 4'h0, 4'hF, '0, 1'b1, "R7 none active gives none");

    // R8 single-thread build
    @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      logic ev;
      s_status = 3'(c);
      #2;
      ev = (c == 0 || c == 1 || c == 4);
      chk(s_v, {1'b0, s_t}, ev, 2'd0, $sformatf("R8 single thread status %0d", c));
    end

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule